// File: doc/BRIEF.md
# Sticky-Mode Watchdog and Interval Timer

The block counts ticks from an external prescaler. When the count wraps, it takes one of three actions, chosen by a two-bit mode field. In interval mode it raises a maskable interrupt and keeps counting. In the first watchdog mode it raises a non-maskable interrupt. In the second watchdog mode it raises a reset request. Software controls the block through one 8-bit control register that carries a run bit and the mode field. The register takes both byte writes and single-bit writes, and it can be read back at any time.

A write to the control register only takes effect when it comes straight after a write to a separate command address. Once the run bit or either mode bit has been set, software cannot clear it; only a hardware reset clears it. Writing 1 to the run bit zeroes the counter. Software uses this write both to start the timer and to service it while it runs.

Top module: `wdt_sticky`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x00 and `irq_intv`, `irq_nmi`, `rst_req` and `seq_err` are all 0.
- R2: Only bit 7 (run), bit 4 (mode high) and bit 3 (mode low) are implemented. Every other bit of `ctrl_rdata` reads 0, whatever was written to it.
- R3: A write to the control address (0) takes effect only if the bus write just before it went to the command address (1). Any other control write leaves the register unchanged.
- R4: After a command-address write, if the next bus write goes to any address other than 0, that write is discarded, `seq_err` goes to 1 and stays at 1 until reset, and the unlock is used up.
- R5: Accepted writes can set the run bit and the mode bits but can never clear them.
- R6: With `bus_bitwr` = 1, an accepted write changes only the bit selected by `bus_bitsel` and loads it from `bus_wdata[0]`.
- R7: An accepted write that puts 1 into the run bit clears the counter, whether or not the counter is already running.
- R8: While the timer runs, the counter advances once per cycle in which `tick` is 1. The overflow action appears on the outputs one cycle after the tick that takes the count from all ones to zero, which is 2^CNT_W ticks after the start or after the last wrap.
- R9: In mode 00, each overflow gives a one-cycle pulse on `irq_intv`, and counting goes on from zero.
- R10: In mode 01, each overflow gives a one-cycle pulse on `irq_nmi`.
- R11: In modes 10 and 11, an overflow sets `rst_req`, which stays at 1 until a hardware reset.
- R12: If a run-bit write arrives in the same cycle as the tick that would overflow, the counter is cleared and no overflow action occurs.
- R13: The counter does not advance while the run bit is 0 or while `tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Count enable from the prescaler |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Write address: 0 = control register, 1 = command (unlock) register |
| bus_bitwr | input | 1 | 1 = single-bit write, 0 = byte write |
| bus_bitsel | input | 3 | Bit index used for a single-bit write |
| bus_wdata | input | 8 | Write data; bit 0 is the value in a single-bit write |
| ctrl_rdata | output | 8 | Read-back of the control register |
| irq_intv | output | 1 | Maskable interval interrupt pulse |
| irq_nmi | output | 1 | Non-maskable interrupt pulse |
| rst_req | output | 1 | Held reset request |
| seq_err | output | 1 | Protected-sequence violation flag |

## Verification
Two functions can fall in the same cycle: the service write that clears the counter and the tick that would wrap it. The bench provokes this by timing the command write and the control write so that the control write lands on the same edge as the 2^CNT_W-th tick in watchdog mode 1. It then checks two things: `irq_nmi` stays low at the point where the pulse would have appeared, and the next pulse comes a full 2^CNT_W ticks after that service edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTRL_W  = 8;
  localparam int RUN_BIT = 7;
  localparam int MHI_BIT = 4;
  localparam int MLO_BIT = 3;

  typedef enum logic [1:0] {
    MODE_INTV = 2'b00,
    MODE_NMI  = 2'b01,
    MODE_RSTA = 2'b10,
    MODE_RSTB = 2'b11
  } wdt_mode_e;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int CMD_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_bitwr,
  input  logic [2:0]        bus_bitsel,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic              run_o,
  output wdt_mode_e         mode_o,
  output logic              restart_o,
  output logic              seq_err_o,
  output logic [CTRL_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);

  logic              armed_q, armed_d;
  logic              run_q, run_d;
  logic [1:0]        mode_q, mode_d;
  logic              err_q, err_d;
  logic              is_ctrl, is_cmd, commit, wr_run;
  logic [CTRL_W-1:0] cur, wval;

  always_comb begin
    cur          = '0;
    cur[RUN_BIT] = run_q;
    cur[MHI_BIT] = mode_q[1];
    cur[MLO_BIT] = mode_q[0];
    wval = bus_wdata;
    if (bus_bitwr) begin
      wval             = cur;
      wval[bus_bitsel] = bus_wdata[0];
    end
    is_ctrl = bus_we && (bus_addr == CTRL_A);
    is_cmd  = bus_we && (bus_addr == CMD_A);
    commit  = armed_q && is_ctrl;
    wr_run  = bus_bitwr ? ((bus_bitsel == 3'(RUN_BIT)) && bus_wdata[0])
                        : bus_wdata[RUN_BIT];
    armed_d = bus_we ? is_cmd : armed_q;
    err_d   = err_q | (armed_q && bus_we && !is_ctrl);
    run_d   = run_q | (commit && wr_run);
    mode_d  = mode_q | (commit ? {wval[MHI_BIT], wval[MLO_BIT]} : 2'b00);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      mode_q  <= 2'b00;
      err_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      run_q   <= run_d;
      mode_q  <= mode_d;
      err_q   <= err_d;
    end
  end

  assign run_o     = run_q;
  assign mode_o    = wdt_mode_e'(mode_q);
  assign restart_o = commit && wr_run;
  assign seq_err_o = err_q;
  assign rdata_o   = cur;

  // R5
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    run_q |=> run_q);
  // R5
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    |mode_q |=> ((mode_q & $past(mode_q)) == $past(mode_q)));
  // R3
  unarmed_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_we && bus_addr == CTRL_A && !armed_q) |=> $stable(rdata_o));
  // R4
  seq_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    err_q |=> err_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic run_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv;

  always_comb begin
    adv   = run_i && tick_i;
    cnt_d = cnt_q;
    if (restart_i)
      cnt_d = '0;
    else if (adv)
      cnt_d = cnt_q + 1'b1;
    ovf_o = adv && !restart_i && (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    restart_i |=> (cnt_q == '0));
  // R13
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!restart_i && !(run_i && tick_i)) |=> $stable(cnt_q));
  // R8
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ovf_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sn,
  input  logic      ovf_i,
  input  wdt_mode_e mode_i,
  output logic      irq_o,
  output logic      nmi_o,
  output logic      rst_req_o
);
  logic irq_q, irq_d, nmi_q, nmi_d, rr_q, rr_d;

  always_comb begin
    irq_d = ovf_i && (mode_i == MODE_INTV);
    nmi_d = ovf_i && (mode_i == MODE_NMI);
    rr_d  = rr_q || (ovf_i && (mode_i == MODE_RSTA || mode_i == MODE_RSTB));
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
      rr_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      nmi_q <= nmi_d;
      rr_q  <= rr_d;
    end
  end

  assign irq_o     = irq_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = rr_q;

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_q |=> !irq_q);
  // R10
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    nmi_q |=> !nmi_q);
  // R11
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rr_q |=> rr_q);
  // R9
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({irq_q, nmi_q}));
endmodule

// File: rtl/wdt_sticky.sv
module wdt_sticky
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int CMD_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_bitwr,
  input  logic [2:0]        bus_bitsel,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        ctrl_rdata,
  output logic              irq_intv,
  output logic              irq_nmi,
  output logic              rst_req,
  output logic              seq_err
);
  logic [1:0] rsync_q;
  logic       rst_sn;
  logic       run, restart, ovf;
  wdt_mode_e  mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  wdt_ctrl_reg #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_reg (
    .clk(clk), .rst_sn(rst_sn), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_bitwr(bus_bitwr), .bus_bitsel(bus_bitsel), .bus_wdata(bus_wdata),
    .run_o(run), .mode_o(mode), .restart_o(restart), .seq_err_o(seq_err),
    .rdata_o(ctrl_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_sn(rst_sn), .run_i(run), .tick_i(tick),
    .restart_i(restart), .ovf_o(ovf)
  );

  wdt_action u_act (
    .clk(clk), .rst_sn(rst_sn), .ovf_i(ovf), .mode_i(mode),
    .irq_o(irq_intv), .nmi_o(irq_nmi), .rst_req_o(rst_req)
  );

  // R12
  service_wins_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    restart |=> !(irq_intv || irq_nmi));
endmodule

// File: tb/sim_wdt_sticky.sv
`timescale 1ns/1ps
module sim_wdt_sticky;
  localparam int CW   = 8;
  localparam int FULL = 1 << CW;
  localparam int NV   = 10;
  // {protected, bit-write, bit index, data, expected read-back}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h00},  // R1 nothing set
    {1'b0, 1'b0, 3'd0, 8'h08, 8'h00},  // R3 unprotected ignored
    {1'b1, 1'b0, 3'd0, 8'h67, 8'h00},  // R2 unimplemented bits
    {1'b1, 1'b0, 3'd0, 8'h08, 8'h08},  // R3 protected accepted
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h08},  // R5 mode low sticky
    {1'b1, 1'b1, 3'd4, 8'h01, 8'h18},  // R6 bit write sets mode high
    {1'b1, 1'b1, 3'd3, 8'h00, 8'h18},  // R6 bit write 0 cannot clear
    {1'b1, 1'b1, 3'd7, 8'h01, 8'h98},  // R6 bit write sets run
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h98},  // R5 run sticky
    {1'b0, 1'b0, 3'd0, 8'h00, 8'h98}   // R3 unprotected ignored
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_bitwr = 1'b0;
  logic [2:0] bus_bitsel = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic       irq_intv, irq_nmi, rst_req, seq_err;
  int nchk = 0;
  int nfail = 0;
  int n;

  always #4 clk = ~clk;

  wdt_sticky #(.CNT_W(CW), .ADDR_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_bitwr(bus_bitwr), .bus_bitsel(bus_bitsel),
    .bus_wdata(bus_wdata), .ctrl_rdata(ctrl_rdata), .irq_intv(irq_intv),
    .irq_nmi(irq_nmi), .rst_req(rst_req), .seq_err(seq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic bm,
                        input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_bitwr = bm; bus_bitsel = idx; bus_wdata = d;
    @(posedge clk);
  endtask

  task automatic bus_idle();
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic prot_wr(input logic bm, input logic [2:0] idx, input logic [7:0] d);
    bus_wr(2'd1, 1'b0, 3'd0, 8'hA5);
    bus_wr(2'd0, bm, idx, d);
  endtask

  // returns cycles until sig (0 irq, 1 nmi, 2 rst_req) is seen, 0 if never
  task automatic wait_evt(input int which, input int maxc, output int cnt);
    cnt = 0;
    for (int k = 1; k <= maxc; k++) begin
      @(posedge clk); @(negedge clk);
      if ((which == 0 && irq_intv) || (which == 1 && irq_nmi) ||
          (which == 2 && rst_req)) begin
        cnt = k;
        break;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 rdata", int'(ctrl_rdata), 0);
    chk("R1 outputs", int'({irq_intv, irq_nmi, rst_req, seq_err}), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) prot_wr(VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      else            bus_wr(2'd0, VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      bus_idle();
      chk($sformatf("R2/R3/R5/R6 vector %0d", i), int'(ctrl_rdata), int'(VEC[i][7:0]));
    end
    chk("R4 no error from clean sequences", int'(seq_err), 0);

    // R4 broken sequence
    do_reset();
    bus_wr(2'd1, 1'b0, 3'd0, 8'h00);
    bus_wr(2'd2, 1'b0, 3'd0, 8'h80);
    bus_wr(2'd0, 1'b0, 3'd0, 8'h88);
    bus_idle();
    chk("R4 seq_err set", int'(seq_err), 1);
    chk("R4 control unchanged", int'(ctrl_rdata), 0);
    prot_wr(1'b0, 3'd0, 8'h08);
    bus_idle();
    chk("R4 later write accepted", int'(ctrl_rdata), 8'h08);
    chk("R4 seq_err held", int'(seq_err), 1);

    // R13 no counting while stopped
    do_reset();
    tick = 1'b1;
    wait_evt(0, 3 * FULL, n);
    chk("R13 stopped timer silent", n, 0);
    // R13 no counting without tick
    do_reset();
    prot_wr(1'b0, 3'd0, 8'h80);
    bus_idle();
    wait_evt(0, 2 * FULL, n);
    chk("R13 no tick no overflow", n, 0);
    tick = 1'b1;
    wait_evt(0, 2 * FULL, n);
    chk("R8 overflow after full count", n, FULL);

    // R9 interval mode
    do_reset();
    tick = 1'b1;
    prot_wr(1'b0, 3'd0, 8'h80);
    bus_idle();
    wait_evt(0, 2 * FULL, n);
    chk("R9 first interval irq", n, FULL);
    chk("R9 no nmi/rst", int'({irq_nmi, rst_req}), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 irq one cycle", int'(irq_intv), 0);
    wait_evt(0, 2 * FULL, n);
    chk("R9 repeat interval", n, FULL - 1);

    // R10 nmi mode
    do_reset();
    tick = 1'b1;
    prot_wr(1'b0, 3'd0, 8'h88);
    bus_idle();
    wait_evt(1, 2 * FULL, n);
    chk("R10 nmi after full count", n, FULL);
    chk("R10 no irq", int'(irq_intv), 0);
    @(posedge clk); @(negedge clk);
    chk("R10 nmi one cycle", int'(irq_nmi), 0);

    // R11 reset request mode
    do_reset();
    tick = 1'b1;
    prot_wr(1'b0, 3'd0, 8'h90);
    bus_idle();
    wait_evt(2, 2 * FULL, n);
    chk("R11 rst_req after full count", n, FULL);
    repeat (FULL + 20) @(negedge clk);
    chk("R11 rst_req held", int'(rst_req), 1);
    do_reset();
    chk("R11 rst_req cleared by reset", int'(rst_req), 0);
    chk("R1 control cleared by reset", int'(ctrl_rdata), 0);

    // R7 service while running
    do_reset();
    tick = 1'b1;
    prot_wr(1'b0, 3'd0, 8'h88);
    bus_idle();
    repeat (100) begin @(posedge clk); @(negedge clk); end
    prot_wr(1'b0, 3'd0, 8'h80);
    bus_idle();
    chk("R5 mode kept after service", int'(ctrl_rdata), 8'h88);
    wait_evt(1, 2 * FULL, n);
    chk("R7 service restarts count", n, FULL);

    // R12 service on the overflow tick
    do_reset();
    tick = 1'b1;
    prot_wr(1'b0, 3'd0, 8'h88);
    bus_idle();
    repeat (FULL - 3) begin @(posedge clk); @(negedge clk); end
    prot_wr(1'b0, 3'd0, 8'h80);
    bus_idle();
    chk("R12 no nmi on coinciding service", int'(irq_nmi), 0);
    wait_evt(1, 2 * FULL, n);
    chk("R12 next nmi full count later", n, FULL);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule